// File: doc/BRIEF.md
# ECC-First Page Read Column Sequencer

This block runs the column-address side of a flash page read that has hardware error correction. When correction is on, it points the first read at the column where the stored check bytes sit, at the tail of the spare area. It passes those check bytes to an external checker. It then moves the flash column back to zero with a two-opcode column-change sequence held in a register. After that it streams the main area through the checker in packets of `STEP_BYTES`. Each packet is held in a local buffer and released on the output stream only once the checker has reported on it.

Command and address bytes leave on a valid/ready stream. Flash read bytes arrive on a second stream, checker bytes leave on a third, and corrected packets leave on a fourth. A producer holds valid and its payload steady until ready is seen high at a clock edge. A consumer may drop ready at any cycle, and the transfer then waits with no loss. Configuration writes, start, done, busy and the error flag are plain level or pulse pins. The BCH encoder and decoder are outside the block. The checker answers each data packet with a single-cycle done pulse and an ok bit.

Top module: `ecc_first_rdseq`

## Requirements
- R1: After reset, busy, done, page_err, bus_valid, chk_valid and out_valid are all 0.
- R2: A write with cfg_sel=0 loads the correction word: bits 15:0 hold the check-byte start column, bits 26:16 hold the check length in bytes, and bit 27 enables correction. A write with cfg_sel=1 loads the column-change word: bits 7:0 hold the first opcode, bits 15:8 the second opcode, and bits 30:28 the number of column address bytes. Writes while busy are dropped. A write in the same cycle as start is kept and used by that read.
- R3: With correction on, a read emits these bytes on the bus stream, in order: command 0x00; the start column, low byte first, one byte for page code 0 and two bytes otherwise; ROW_BYTES row bytes, low byte first; command 0x30. bus_is_cmd is 1 on command bytes and 0 on address bytes.
- R4: After the header, exactly the configured check length of flash bytes is forwarded unchanged to the checker with chk_ecc=1.
- R5: The block then emits the first column-change opcode, the configured count of 0x00 address bytes, and the second opcode.
- R6: Page codes map to page sizes as 0=512, 5=1024, 1=2048, 2=4096, 3=8192, 4=16384 bytes. The page is read in page/STEP_BYTES packets. Each data byte goes to the checker with chk_ecc=0.
- R7: A packet appears on the output only after its chk_done. Its bytes come out in flash order, and out_last marks the final byte of each packet.
- R8: chk_done with chk_ok=0 sets page_err. The packet is still delivered. page_err stays set until the next accepted start.
- R9: With correction off, the column bytes are zero. There is no check read and no column change. chk_valid stays 0, and packets are output with no wait on the checker.
- R10: done is a single-cycle pulse after the last output byte, and busy falls in the next cycle.
- R11: A start with page code 6 or 7 is ignored.
- R12: fl_ready is 0 outside the two read phases. While correction is on, fl_ready is 0 whenever chk_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = correction word, 1 = column-change word |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Begin a page read |
| page_code | input | 3 | Page-size code |
| row_addr | input | 8*ROW_BYTES | Row (page) address |
| busy | output | 1 | Read in progress |
| done | output | 1 | End-of-page pulse |
| page_err | output | 1 | Sticky uncorrectable flag |
| bus_valid | output | 1 | Command/address byte valid |
| bus_ready | input | 1 | Command/address byte accepted |
| bus_is_cmd | output | 1 | 1 = command byte, 0 = address byte |
| bus_byte | output | 8 | Command or address value |
| fl_valid | input | 1 | Flash read byte valid |
| fl_ready | output | 1 | Flash read byte accepted |
| fl_data | input | 8 | Flash read byte |
| chk_valid | output | 1 | Checker byte valid |
| chk_ready | input | 1 | Checker accepts byte |
| chk_ecc | output | 1 | 1 = stored check byte, 0 = data byte |
| chk_data | output | 8 | Checker byte |
| chk_done | input | 1 | Packet check finished (pulse) |
| chk_ok | input | 1 | Packet correctable |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a packet |

## Verification
Two events can land in the same cycle. The first is a configuration write that coincides with the start pulse. The bench drives both in one cycle and judges the outcome by the number of check bytes read and the column bytes emitted, both of which must follow the new word. A second write made mid-read must leave that read unchanged. The other coincidence is a flash byte accepted in the same cycle as its checker transfer. The checker and output stalls follow patterns that hit the bus, flash and output streams in varied phases, and every transfer is compared against queues that the bench builds from the requirements.

// File: rtl/ncs_pkg.sv
package ncs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ACOL, S_AROW, S_CMD2, S_ECC,
    S_XCMD1, S_XADDR, S_XCMD2, S_PIN, S_WCHK, S_POUT, S_FIN
  } seq_st_e;

  // page-size code to bytes; unknown codes give 0
  function automatic logic [15:0] page_bytes(input logic [2:0] code);
    case (code)
      3'd0:    page_bytes = 16'd512;
      3'd5:    page_bytes = 16'd1024;
      3'd1:    page_bytes = 16'd2048;
      3'd2:    page_bytes = 16'd4096;
      3'd3:    page_bytes = 16'd8192;
      3'd4:    page_bytes = 16'd16384;
      default: page_bytes = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/ncs_regs.sv
module ncs_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [15:0] ecc_col,
  output logic [10:0] ecc_len,
  output logic        bch_en,
  output logic [7:0]  xcmd1,
  output logic [7:0]  xcmd2,
  output logic [2:0]  xnaddr
);
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31], cfg_wdata[29:28] & 2'b00, cfg_wdata[27:16] & 12'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_col <= '0; ecc_len <= '0; bch_en <= 1'b0;
      xcmd1 <= '0; xcmd2 <= '0; xnaddr <= '0;
    end else if (cfg_we && !busy) begin
      if (!cfg_sel) begin
        ecc_col <= cfg_wdata[15:0];
        ecc_len <= cfg_wdata[26:16];
        bch_en  <= cfg_wdata[27];
      end else begin
        xcmd1  <= cfg_wdata[7:0];
        xcmd2  <= cfg_wdata[15:8];
        xnaddr <= cfg_wdata[30:28];
      end
    end
  end

  // R2
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(busy)) |-> ($stable(ecc_col) && $stable(ecc_len) &&
      $stable(bch_en) && $stable(xcmd1) && $stable(xcmd2) && $stable(xnaddr)));

endmodule

// File: rtl/ncs_pktbuf.sv
module ncs_pktbuf #(
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/ncs_ctrl.sv
module ncs_ctrl
  import ncs_pkg::*;
#(
  parameter int STEP_BYTES = 512,
  parameter int ROW_BYTES  = 3,
  parameter logic [7:0] RD_OP1 = 8'h00,
  parameter logic [7:0] RD_OP2 = 8'h30,
  localparam int IW = $clog2(STEP_BYTES),
  localparam int CW = $clog2(STEP_BYTES + 2048),
  localparam int SW = $clog2(16384 / STEP_BYTES) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             page_code,
  input  logic [8*ROW_BYTES-1:0] row_addr,
  input  logic [15:0]            ecc_col,
  input  logic [10:0]            ecc_len,
  input  logic                   bch_en,
  input  logic [7:0]             xcmd1,
  input  logic [7:0]             xcmd2,
  input  logic [2:0]             xnaddr,
  output logic                   busy,
  output logic                   done,
  output logic                   page_err,
  output logic                   bus_valid,
  input  logic                   bus_ready,
  output logic                   bus_is_cmd,
  output logic [7:0]             bus_byte,
  input  logic                   fl_valid,
  output logic                   fl_ready,
  input  logic [7:0]             fl_data,
  output logic                   chk_valid,
  input  logic                   chk_ready,
  output logic                   chk_ecc,
  output logic [7:0]             chk_data,
  input  logic                   chk_done,
  input  logic                   chk_ok,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_last,
  output logic                   buf_we,
  output logic [IW-1:0]          buf_idx
);
  seq_st_e st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] stp, steps_q;
  logic [1:0] colcyc_q;
  logic [8*ROW_BYTES-1:0] row_q, rsh;
  logic [15:0] col_w, pb;
  logic [SW-1:0] nsteps;
  logic fl_take, last_byte;

  assign pb     = page_bytes(page_code);
  assign nsteps = (SW'(pb >> IW) == '0) ? SW'(1) : SW'(pb >> IW);
  assign col_w  = bch_en ? ecc_col : 16'h0;
  assign rsh    = row_q >> {cnt, 3'b000};
  assign last_byte = (cnt == CW'(STEP_BYTES - 1));

  always_comb begin
    bus_valid  = 1'b0;
    bus_is_cmd = 1'b0;
    bus_byte   = 8'h00;
    case (st)
      S_CMD1:  begin bus_valid = 1'b1; bus_is_cmd = 1'b1; bus_byte = RD_OP1; end
      S_ACOL:  begin bus_valid = 1'b1; bus_byte = cnt[0] ? col_w[15:8] : col_w[7:0]; end
      S_AROW:  begin bus_valid = 1'b1; bus_byte = rsh[7:0]; end
      S_CMD2:  begin bus_valid = 1'b1; bus_is_cmd = 1'b1; bus_byte = RD_OP2; end
      S_XCMD1: begin bus_valid = 1'b1; bus_is_cmd = 1'b1; bus_byte = xcmd1; end
      S_XADDR: begin bus_valid = 1'b1; end
      S_XCMD2: begin bus_valid = 1'b1; bus_is_cmd = 1'b1; bus_byte = xcmd2; end
      default: ;
    endcase
  end

  always_comb begin
    fl_ready = 1'b0;
    if (st == S_ECC) fl_ready = chk_ready;
    else if (st == S_PIN) fl_ready = bch_en ? chk_ready : 1'b1;
  end

  assign chk_valid = fl_valid && ((st == S_ECC) || (st == S_PIN && bch_en));
  assign chk_ecc   = (st == S_ECC);
  assign chk_data  = fl_data;
  assign fl_take   = fl_valid && fl_ready;
  assign buf_we    = (st == S_PIN) && fl_take;
  assign buf_idx   = cnt[IW-1:0];
  assign out_valid = (st == S_POUT);
  assign out_last  = out_valid && last_byte;
  assign done      = (st == S_FIN);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; stp <= '0; steps_q <= '0;
      colcyc_q <= '0; row_q <= '0; page_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && pb != 16'h0) begin
          row_q    <= row_addr;
          steps_q  <= nsteps;
          colcyc_q <= (page_code == 3'd0) ? 2'd1 : 2'd2;
          page_err <= 1'b0;
          cnt <= '0; stp <= '0;
          st  <= S_CMD1;
        end
        S_CMD1: if (bus_ready) st <= S_ACOL;
        S_ACOL: if (bus_ready) begin
          if (cnt == CW'(colcyc_q) - CW'(1)) begin cnt <= '0; st <= S_AROW; end
          else cnt <= cnt + 1'b1;
        end
        S_AROW: if (bus_ready) begin
          if (cnt == CW'(ROW_BYTES - 1)) begin cnt <= '0; st <= S_CMD2; end
          else cnt <= cnt + 1'b1;
        end
        S_CMD2: if (bus_ready) begin
          if (!bch_en) st <= S_PIN;
          else if (ecc_len != '0) st <= S_ECC;
          else st <= S_XCMD1;
        end
        S_ECC: if (fl_take) begin
          if (cnt == CW'(ecc_len) - CW'(1)) begin cnt <= '0; st <= S_XCMD1; end
          else cnt <= cnt + 1'b1;
        end
        S_XCMD1: if (bus_ready) st <= (xnaddr != '0) ? S_XADDR : S_XCMD2;
        S_XADDR: if (bus_ready) begin
          if (cnt == CW'(xnaddr) - CW'(1)) begin cnt <= '0; st <= S_XCMD2; end
          else cnt <= cnt + 1'b1;
        end
        S_XCMD2: if (bus_ready) st <= S_PIN;
        S_PIN: if (fl_take) begin
          if (last_byte) begin cnt <= '0; st <= bch_en ? S_WCHK : S_POUT; end
          else cnt <= cnt + 1'b1;
        end
        S_WCHK: if (chk_done) begin
          if (!chk_ok) page_err <= 1'b1;
          st <= S_POUT;
        end
        S_POUT: if (out_ready) begin
          if (last_byte) begin
            cnt <= '0;
            if (stp == steps_q - SW'(1)) st <= S_FIN;
            else begin stp <= stp + 1'b1; st <= S_PIN; end
          end else cnt <= cnt + 1'b1;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_byte) && $stable(bus_is_cmd)));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(chk_done && !chk_ok));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_ready && !bus_valid && !out_valid && !chk_valid));
  // R4
  chk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> fl_valid);

endmodule

// File: rtl/ecc_first_rdseq.sv
module ecc_first_rdseq #(
  parameter int STEP_BYTES = 512,
  parameter int ROW_BYTES  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [31:0]            cfg_wdata,
  input  logic                   start,
  input  logic [2:0]             page_code,
  input  logic [8*ROW_BYTES-1:0] row_addr,
  output logic                   busy,
  output logic                   done,
  output logic                   page_err,
  output logic                   bus_valid,
  input  logic                   bus_ready,
  output logic                   bus_is_cmd,
  output logic [7:0]             bus_byte,
  input  logic                   fl_valid,
  output logic                   fl_ready,
  input  logic [7:0]             fl_data,
  output logic                   chk_valid,
  input  logic                   chk_ready,
  output logic                   chk_ecc,
  output logic [7:0]             chk_data,
  input  logic                   chk_done,
  input  logic                   chk_ok,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_last
);
  localparam int IW = $clog2(STEP_BYTES);

  logic [15:0] ecc_col;
  logic [10:0] ecc_len;
  logic        bch_en;
  logic [7:0]  xcmd1, xcmd2;
  logic [2:0]  xnaddr;
  logic        buf_we;
  logic [IW-1:0] buf_idx;

  ncs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ecc_col(ecc_col), .ecc_len(ecc_len), .bch_en(bch_en),
    .xcmd1(xcmd1), .xcmd2(xcmd2), .xnaddr(xnaddr)
  );

  ncs_ctrl #(.STEP_BYTES(STEP_BYTES), .ROW_BYTES(ROW_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .page_code(page_code), .row_addr(row_addr),
    .ecc_col(ecc_col), .ecc_len(ecc_len), .bch_en(bch_en), .xcmd1(xcmd1), .xcmd2(xcmd2),
    .xnaddr(xnaddr), .busy(busy), .done(done), .page_err(page_err),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_is_cmd(bus_is_cmd), .bus_byte(bus_byte),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_data(fl_data),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_ecc(chk_ecc), .chk_data(chk_data),
    .chk_done(chk_done), .chk_ok(chk_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .buf_we(buf_we), .buf_idx(buf_idx)
  );

  ncs_pktbuf #(.DEPTH(STEP_BYTES)) u_buf (
    .clk(clk), .wr_en(buf_we), .idx(buf_idx), .wdata(fl_data), .rdata(out_data)
  );

endmodule

// File: tb/sim_ecc_first_rdseq.sv
module sim_ecc_first_rdseq;
  localparam int STEP = 512;
  localparam int ROWB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic start = 0;
  logic [2:0] page_code = '0;
  logic [8*ROWB-1:0] row_addr = '0;
  logic busy, done, page_err, bus_valid, bus_is_cmd, fl_ready, chk_valid, chk_ecc;
  logic out_valid, out_last;
  logic [7:0] bus_byte, chk_data, out_data;
  logic bus_ready = 0, fl_valid = 0, chk_ready = 0, chk_done = 0, chk_ok = 0, out_ready = 0;
  logic [7:0] fl_data = '0;

  always #5 clk = ~clk;

  ecc_first_rdseq #(.STEP_BYTES(STEP), .ROW_BYTES(ROWB)) u0 (.*);

  int vecs = 0, errs = 0, cyc = 0;
  // model registers
  logic [15:0] m_col = 0; logic [10:0] m_len = 0; logic m_bch = 0;
  logic [7:0] m_x1 = 0, m_x2 = 0; logic [2:0] m_xn = 0;
  logic m_busy = 0, exp_err = 0;
  logic [8:0] exp_bus [$];
  logic [7:0] exp_out [$];
  int hdr_len, bus_total, bus_seen, fl_cnt, fl_total, chk_rx, dones_given, out_cnt, n_done;
  int chk_timer = 0, chk_pkt = 0, chk_mode = 0, ndone_prev = 0;
  logic [31:0] fail_mask = 0;
  logic prev_done = 0;

  function automatic int pbytes(input int code);
    case (code) 0: return 512; 5: return 1024; 1: return 2048; 2: return 4096;
      3: return 8192; 4: return 16384; default: return 0; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time); end
  endtask

  task automatic model_write(input bit sel, input logic [31:0] d);
    if (m_busy) return;
    if (!sel) begin m_col = d[15:0]; m_len = d[26:16]; m_bch = d[27]; end
    else begin m_x1 = d[7:0]; m_x2 = d[15:8]; m_xn = d[30:28]; end
  endtask

  task automatic wr_cfg(input bit sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d; model_write(sel, d);
    @(negedge clk); cfg_we = 0;
  endtask

  // drive + check, once per cycle away from the clock edge
  always begin
    @(negedge clk);
    cyc++;
    bus_ready = (cyc % 5) != 2;
    fl_valid  = (cyc % 7) != 3;
    out_ready = (cyc % 4) != 1;
    chk_ready = (chk_mode == 0) ? 1'b1 : (chk_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
    fl_data   = 8'((fl_cnt * 37 + 11 + n_done * 5) & 255);
    chk_done = 0;
    if (chk_timer > 0) begin
      chk_timer--;
      if (chk_timer == 0) begin chk_done = 1; chk_ok = !fail_mask[chk_pkt]; dones_given++; end
    end
    #1;
    if (cyc > 150000) begin
      errs++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs); $finish;
    end
    if (m_busy && m_bch && !chk_ready)  // R12
      chk(!fl_ready, "R12 fl_ready while checker stalled", fl_ready, 0);
    if (m_busy && !m_bch)  // R9
      chk(!chk_valid, "R9 chk_valid with correction off", chk_valid, 0);
    if (bus_valid && bus_ready) begin  // R3 R5
      if (exp_bus.size() == 0) chk(0, "R3 unexpected bus byte", {bus_is_cmd, bus_byte}, 0);
      else begin
        logic [8:0] e; e = exp_bus.pop_front();
        chk({bus_is_cmd, bus_byte} == e, bus_seen < hdr_len ? "R3 header byte" : "R5 column change byte",
            {bus_is_cmd, bus_byte}, e);
      end
      bus_seen++;
    end
    if (fl_valid && fl_ready) begin
      if (m_bch && fl_cnt < m_len) begin  // R4
        chk(bus_seen == hdr_len, "R4 check read after header", bus_seen, hdr_len);
        chk(chk_valid && chk_ready && chk_ecc && chk_data == fl_data, "R4 check byte to checker",
            {chk_valid, chk_ecc, chk_data}, {2'b11, fl_data});
      end else begin  // R6
        chk(bus_seen == bus_total, "R6 data after column change", bus_seen, bus_total);
        exp_out.push_back(fl_data);
        chk(exp_out.size() <= STEP, "R6 packet read before drain", exp_out.size(), STEP);
        if (m_bch) begin
          chk(chk_valid && chk_ready && !chk_ecc && chk_data == fl_data, "R6 data byte to checker",
              {chk_valid, chk_ecc, chk_data}, {2'b10, fl_data});
          chk_rx++;
          if (chk_rx % STEP == 0) begin chk_timer = 4; chk_pkt = chk_rx / STEP - 1; end
        end
      end
      fl_cnt++;
    end
    if (out_valid && out_ready) begin  // R7
      if (m_bch) chk(dones_given > out_cnt / STEP, "R7 output before check done", dones_given, out_cnt / STEP + 1);
      if (exp_out.size() == 0) chk(0, "R7 unexpected output byte", out_data, 0);
      else begin
        logic [7:0] e; e = exp_out.pop_front();
        chk(out_data == e, "R7 output data", out_data, e);
      end
      chk(out_last == ((out_cnt % STEP) == STEP - 1), "R7 out_last", out_last, (out_cnt % STEP) == STEP - 1);
      out_cnt++;
    end
    if (done) begin  // R10 R8
      chk(!prev_done, "R10 done longer than one cycle", 1, 0);
      chk(m_busy && exp_out.size() == 0 && exp_bus.size() == 0 && fl_cnt == fl_total,
          "R10 done before page complete", fl_cnt, fl_total);
      chk(page_err == exp_err, "R8 page_err at done", page_err, exp_err);
      n_done++; m_busy = 0;
    end
    prev_done = done;
  end

  task automatic run_page(input int code, input logic [23:0] row, input logic [31:0] fm,
                          input bit with_cfg, input logic [31:0] cw, input bit late_wr);
    int pb, ns, ncol;
    logic [15:0] col;
    @(negedge clk);
    start = 1; page_code = 3'(code); row_addr = row;
    if (with_cfg) begin cfg_we = 1; cfg_sel = 0; cfg_wdata = cw; model_write(0, cw); end
    pb = pbytes(code); ns = pb / STEP; if (ns == 0) ns = 1;
    fail_mask = fm; exp_err = 0;
    if (m_bch) for (int i = 0; i < ns; i++) if (fm[i]) exp_err = 1;
    exp_bus.delete(); exp_out.delete();
    col = m_bch ? m_col : 16'h0; ncol = (code == 0) ? 1 : 2;
    exp_bus.push_back({1'b1, 8'h00});
    exp_bus.push_back({1'b0, col[7:0]});
    if (ncol == 2) exp_bus.push_back({1'b0, col[15:8]});
    for (int i = 0; i < ROWB; i++) exp_bus.push_back({1'b0, row[8*i +: 8]});
    exp_bus.push_back({1'b1, 8'h30});
    hdr_len = exp_bus.size();
    if (m_bch) begin
      exp_bus.push_back({1'b1, m_x1});
      for (int i = 0; i < m_xn; i++) exp_bus.push_back({1'b0, 8'h00});
      exp_bus.push_back({1'b1, m_x2});
    end
    bus_total = exp_bus.size();
    fl_total = (m_bch ? m_len : 0) + ns * STEP;
    bus_seen = 0; fl_cnt = 0; chk_rx = 0; dones_given = 0; out_cnt = 0;
    m_busy = 1; ndone_prev = n_done;
    @(negedge clk); start = 0; cfg_we = 0;
    if (late_wr) begin
      repeat (15) @(negedge clk);
      cfg_we = 1; cfg_sel = 0; cfg_wdata = {4'b0, 1'b1, 11'd3, 16'h0456}; model_write(0, cfg_wdata);
      @(negedge clk); cfg_we = 0;
      repeat (3) @(negedge clk);
      cfg_we = 1; cfg_sel = 1; cfg_wdata = 32'h0000_7711; model_write(1, cfg_wdata);
      @(negedge clk); cfg_we = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    chk(n_done == ndone_prev + 1, "R10 one done per page", n_done, ndone_prev + 1);
    chk(!busy, "R10 busy after done", busy, 0);
    chk(page_err == exp_err, "R8 page_err held after done", page_err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(!busy && !done && !page_err && !bus_valid && !chk_valid && !out_valid,
        "R1 reset state", {busy, done, page_err, bus_valid, chk_valid, out_valid}, 0);
    rst_n = 1;
    // R2: 2048-byte page, 13 check bytes per 512-byte step x4 = 52, start column 2060
    wr_cfg(0, {4'b0, 1'b1, 11'd52, 16'd2060});
    wr_cfg(1, {1'b0, 3'd2, 12'h0, 8'hE0, 8'h05});
    chk_mode = 1;
    run_page(1, 24'h012345, 32'b0100, 0, 0, 0);      // R8 packet 2 uncorrectable
    // R6 512-byte page, one column cycle, t=4 gives 7 bytes at 521
    wr_cfg(0, {4'b0, 1'b1, 11'd7, 16'd521});
    wr_cfg(1, {1'b0, 3'd1, 12'h0, 8'hE0, 8'h05});
    chk_mode = 0;
    run_page(0, 24'hA5C3F0, 0, 0, 0, 0);             // R8 flag cleared by new start
    // R9 correction off, 1024-byte page, checker never ready
    wr_cfg(0, {4'b0, 1'b0, 11'd52, 16'd2060});
    chk_mode = 2;
    run_page(5, 24'h00BEEF, 32'hFFFF, 0, 0, 0);
    // R11 invalid page code
    chk_mode = 0;
    @(negedge clk); start = 1; page_code = 3'd7;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    #2;
    chk(!busy && !bus_valid, "R11 start with code 7 ignored", busy, 0);
    // R2 write in start cycle kept, writes while busy dropped
    run_page(0, 24'h111111, 32'b1, 1, {4'b0, 1'b1, 11'd10, 16'h0123}, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule